// File: doc/BRIEF.md
# Register-Mapped SPI Word Master

This block is an SPI master that software drives through a small 32-bit register bus. Software picks one of eight chip-select lines and enables it through a control register. It sets the word length in a configuration register. Writing the data-out register then starts a transfer of one word, which is 8 or 16 bits long. The block shifts the word out MSB first in SPI mode 0: the serial clock idles low and both ends sample on the rising edge. Meanwhile it assembles the word arriving on MISO.

When the last bit is done, the received word lands in the data-in register in a single cycle and the ready flag in the control register is set. An interrupt cause bit is set at the same time. A mask bit decides whether the cause reaches the interrupt output. The serial clock rate comes from a separate divider. This block only consumes that divider's tick: each tick is worth one half-period of the serial clock.

Top module: `spi_word_master`

## Requirements
- R1: After reset all chip-select lines are high, the serial clock and MOSI are low, the interrupt output is low, and every register reads zero.
- R2: The register offsets are 0x00 control, 0x04 configuration, 0x08 data out, 0x0C data in, 0x10 interrupt cause and 0x14 interrupt mask. Control reads back the enable in bit 0, ready in bit 1 and the chip-select index in bits 4:2. Bit 1 of control ignores writes. Configuration holds the word-size bit in bit 5, and the mask holds its bit in bit 0.
- R3: While the control enable bit is 1, exactly the chip-select line numbered by the index is low. While it is 0, all eight lines are high.
- R4: An accepted data-out write starts a transfer and clears ready. The data is shifted out MSB first in mode 0: the clock idles low and MOSI changes only while the clock is low.
- R5: With configuration bit 5 clear, a transfer is 8 clock pulses. It sends data-out bits 7:0, and data in then holds the received byte in bits 7:0 with bits 15:8 zero.
- R6: With configuration bit 5 set, a transfer is 16 clock pulses. It sends data-out bits 15:0, high byte first, and data in holds the received word in bits 15:8 (first byte) and 7:0.
- R7: After an idle-to-busy write, ready and data in update on the clock edge of the final falling serial-clock edge. In 8-bit mode with a tick on every cycle, that is the 16th clock edge after the write edge. The serial clock is then low.
- R8: The serial clock changes level only on cycles where the tick input is high, one level change per tick.
- R9: Cause bit 0 is set whenever a transfer completes. Writing 1 to it clears it, and writing 0 leaves it unchanged. The interrupt output equals cause bit 0 AND mask bit 0.
- R10: A data-out write during a busy transfer is ignored. The word in flight, its length and the data-out read-back are unchanged.
- R11: The word size is latched at the start of a transfer. Changing configuration bit 5 mid-transfer does not change the current word's length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_addr_i | input | 5 | Register byte offset |
| bus_we_i | input | 1 | Register write strobe |
| bus_wdata_i | input | 32 | Register write data |
| bus_rdata_o | output | 32 | Register read data (combinational on address) |
| sclk_tick_i | input | 1 | Half-period tick from the external clock divider |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| cs_n_o | output | 8 | Active-low chip selects |
| irq_o | output | 1 | Interrupt request |

## Verification
A bit counter that is off by one shows up at once as a wrong number of serial-clock pulses. It also shows up as a data-in word rotated by one place, and both are visible at the end of the very first transfer. A word-size flag that is not latched, or a shift register that is loaded in the wrong half, corrupts the MOSI pattern that the bench's slave model captures. A stale ready or cause bit shows up on the next register read or on irq_o within one cycle of completion. Decoding the chip-select index wrongly pulls the wrong line low as soon as control is written.

// File: rtl/spi_wm_pkg.sv
package spi_wm_pkg;
  localparam int REG_AW = 5;

  localparam logic [REG_AW-1:0] OFS_CTRL  = 5'h00;
  localparam logic [REG_AW-1:0] OFS_CFG   = 5'h04;
  localparam logic [REG_AW-1:0] OFS_DOUT  = 5'h08;
  localparam logic [REG_AW-1:0] OFS_DIN   = 5'h0C;
  localparam logic [REG_AW-1:0] OFS_CAUSE = 5'h10;
  localparam logic [REG_AW-1:0] OFS_MASK  = 5'h14;

  localparam int CTRL_EN  = 0;
  localparam int CTRL_RDY = 1;
  localparam int CTRL_IDX = 2;
  localparam int CFG_W16  = 5;
  localparam int IRQ_RDY  = 0;
endpackage

// File: rtl/spi_wm_csdec.sv
module spi_wm_csdec #(
  parameter int CS_N  = 8,
  parameter int IDX_W = 3
) (
  input  logic             en_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic [CS_N-1:0]  cs_n_o
);
  for (genvar g = 0; g < CS_N; g++) begin : g_line
    assign cs_n_o[g] = !(en_i && (idx_i == IDX_W'(g)));
  end
endmodule

// File: rtl/spi_wm_shifter.sv
module spi_wm_shifter #(
  parameter int WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              w16_i,
  input  logic [WORD_W-1:0] tx_word_i,
  input  logic              tick_i,
  input  logic              miso_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              sclk_o,
  output logic              mosi_o,
  output logic [WORD_W-1:0] rx_word_o
);
  localparam int HALF  = WORD_W / 2;
  localparam int CNT_W = $clog2(WORD_W);

  logic              busy_q, sclk_q, w16_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [WORD_W-1:0] tx_sh_q, rx_sh_q, rx_q;
  logic [CNT_W-1:0]  last_cnt;
  logic              rise, fall;

  assign last_cnt = w16_q ? CNT_W'(WORD_W - 1) : CNT_W'(HALF - 1);
  assign rise     = busy_q && tick_i && !sclk_q;
  assign fall     = busy_q && tick_i && sclk_q;
  assign done_o   = fall && (cnt_q == last_cnt);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      sclk_q  <= 1'b0;
      w16_q   <= 1'b0;
      cnt_q   <= '0;
      tx_sh_q <= '0;
      rx_sh_q <= '0;
      rx_q    <= '0;
    end else if (start_i && !busy_q) begin
      busy_q  <= 1'b1;
      sclk_q  <= 1'b0;
      w16_q   <= w16_i;
      cnt_q   <= '0;
      // short words are left-aligned so the MSB always leaves from the top
      tx_sh_q <= w16_i ? tx_word_i : {tx_word_i[HALF-1:0], {HALF{1'b0}}};
    end else if (rise) begin
      sclk_q  <= 1'b1;
      rx_sh_q <= {rx_sh_q[WORD_W-2:0], miso_i};
    end else if (fall) begin
      sclk_q  <= 1'b0;
      tx_sh_q <= {tx_sh_q[WORD_W-2:0], 1'b0};
      cnt_q   <= cnt_q + 1'b1;
      if (done_o) begin
        busy_q <= 1'b0;
        rx_q   <= w16_q ? rx_sh_q : {{HALF{1'b0}}, rx_sh_q[HALF-1:0]};
      end
    end
  end

  assign busy_o    = busy_q;
  assign sclk_o    = sclk_q;
  assign mosi_o    = busy_q & tx_sh_q[WORD_W-1];
  assign rx_word_o = rx_q;
endmodule

// File: rtl/spi_wm_regs.sv
module spi_wm_regs
  import spi_wm_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int WORD_W = 16,
  parameter int IDX_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [REG_AW-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              busy_i,
  input  logic              done_i,
  input  logic [WORD_W-1:0] rx_word_i,
  output logic              start_o,
  output logic [WORD_W-1:0] tx_word_o,
  output logic              w16_o,
  output logic              cs_en_o,
  output logic [IDX_W-1:0]  cs_idx_o,
  output logic              ready_o,
  output logic              cause_o,
  output logic              irq_o
);
  logic              cs_en_q, w16_q, ready_q, cause_q, mask_q;
  logic [IDX_W-1:0]  cs_idx_q;
  logic [WORD_W-1:0] tx_q;
  logic              wr_ctrl, wr_cfg, wr_cause, wr_mask;
  logic              unused_wdata;

  assign wr_ctrl  = we_i && (addr_i == OFS_CTRL);
  assign wr_cfg   = we_i && (addr_i == OFS_CFG);
  assign wr_cause = we_i && (addr_i == OFS_CAUSE);
  assign wr_mask  = we_i && (addr_i == OFS_MASK);
  assign start_o  = we_i && (addr_i == OFS_DOUT) && !busy_i;
  assign unused_wdata = ^wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_en_q  <= 1'b0;
      cs_idx_q <= '0;
      w16_q    <= 1'b0;
      tx_q     <= '0;
      ready_q  <= 1'b0;
      cause_q  <= 1'b0;
      mask_q   <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        cs_en_q  <= wdata_i[CTRL_EN];
        cs_idx_q <= wdata_i[CTRL_IDX +: IDX_W];
      end
      if (wr_cfg)  w16_q  <= wdata_i[CFG_W16];
      if (wr_mask) mask_q <= wdata_i[IRQ_RDY];
      if (start_o) tx_q   <= wdata_i[WORD_W-1:0];
      if (done_i)       ready_q <= 1'b1;
      else if (start_o) ready_q <= 1'b0;
      // completion wins over a same-cycle clear
      if (done_i)                           cause_q <= 1'b1;
      else if (wr_cause && wdata_i[IRQ_RDY]) cause_q <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      OFS_CTRL: begin
        rdata_o[CTRL_EN]             = cs_en_q;
        rdata_o[CTRL_RDY]            = ready_q;
        rdata_o[CTRL_IDX +: IDX_W]   = cs_idx_q;
      end
      OFS_CFG:   rdata_o[CFG_W16]      = w16_q;
      OFS_DOUT:  rdata_o[WORD_W-1:0]   = tx_q;
      OFS_DIN:   rdata_o[WORD_W-1:0]   = rx_word_i;
      OFS_CAUSE: rdata_o[IRQ_RDY]      = cause_q;
      OFS_MASK:  rdata_o[IRQ_RDY]      = mask_q;
      default:   rdata_o               = '0;
    endcase
  end

  assign tx_word_o = tx_q;
  assign w16_o     = w16_q;
  assign cs_en_o   = cs_en_q;
  assign cs_idx_o  = cs_idx_q;
  assign ready_o   = ready_q;
  assign cause_o   = cause_q;
  assign irq_o     = cause_q & mask_q;
endmodule

// File: rtl/spi_word_master.sv
module spi_word_master
  import spi_wm_pkg::*;
#(
  parameter int CS_N   = 8,
  parameter int DATA_W = 32,
  parameter int WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [REG_AW-1:0] bus_addr_i,
  input  logic              bus_we_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  input  logic              sclk_tick_i,
  output logic              sclk_o,
  output logic              mosi_o,
  input  logic              miso_i,
  output logic [CS_N-1:0]   cs_n_o,
  output logic              irq_o
);
  localparam int IDX_W = $clog2(CS_N);

  logic              start_w, busy_w, done_w, w16_w, cs_en_w, ready_w, cause_w;
  logic [IDX_W-1:0]  cs_idx_w;
  logic [WORD_W-1:0] tx_word_w, rx_word_w;

  spi_wm_regs #(.DATA_W(DATA_W), .WORD_W(WORD_W), .IDX_W(IDX_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .addr_i    (bus_addr_i),
    .we_i      (bus_we_i),
    .wdata_i   (bus_wdata_i),
    .rdata_o   (bus_rdata_o),
    .busy_i    (busy_w),
    .done_i    (done_w),
    .rx_word_i (rx_word_w),
    .start_o   (start_w),
    .tx_word_o (tx_word_w),
    .w16_o     (w16_w),
    .cs_en_o   (cs_en_w),
    .cs_idx_o  (cs_idx_w),
    .ready_o   (ready_w),
    .cause_o   (cause_w),
    .irq_o     (irq_o)
  );

  spi_wm_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_w),
    .w16_i     (w16_w),
    .tx_word_i (bus_wdata_i[WORD_W-1:0]),
    .tick_i    (sclk_tick_i),
    .miso_i    (miso_i),
    .busy_o    (busy_w),
    .done_o    (done_w),
    .sclk_o    (sclk_o),
    .mosi_o    (mosi_o),
    .rx_word_o (rx_word_w)
  );

  spi_wm_csdec #(.CS_N(CS_N), .IDX_W(IDX_W)) u_csdec (
    .en_i   (cs_en_w),
    .idx_i  (cs_idx_w),
    .cs_n_o (cs_n_o)
  );

  logic unused_tx;
  assign unused_tx = ^tx_word_w;
endmodule

// File: rtl/spi_wm_chk.sv
module spi_wm_chk #(
  parameter int CS_N = 8
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            tick_i,
  input logic            sclk_i,
  input logic            mosi_i,
  input logic [CS_N-1:0] cs_n_i,
  input logic            ready_i,
  input logic            cause_i,
  input logic            start_i,
  input logic            irq_i
);
  a_r3_single_cs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~cs_n_i));

  a_r8_sclk_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_i != $past(sclk_i)) |-> $past(tick_i));

  a_r4_mosi_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_i |-> $stable(mosi_i));

  a_r7_ready_clk_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_i |-> !sclk_i);

  a_r9_cause_on_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_i) |-> cause_i);

  a_r4_ready_clr_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ready_i) |-> $past(start_i));

  a_r9_irq_needs_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |-> cause_i);
endmodule

bind spi_word_master spi_wm_chk #(.CS_N(CS_N)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .tick_i  (sclk_tick_i),
  .sclk_i  (sclk_o),
  .mosi_i  (mosi_o),
  .cs_n_i  (cs_n_o),
  .ready_i (ready_w),
  .cause_i (cause_w),
  .start_i (start_w),
  .irq_i   (irq_o)
);

// File: tb/spi_word_master_test.sv
`timescale 1ns/1ps
module spi_word_master_test;
  localparam logic [4:0] A_CTRL = 5'h00, A_CFG = 5'h04, A_DOUT = 5'h08,
                         A_DIN = 5'h0C, A_CAUSE = 5'h10, A_MASK = 5'h14;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        tick = 1'b0;
  logic        sclk, mosi, miso, irq;
  logic [7:0]  cs_n;

  int checks = 0, fails = 0;
  bit finished = 1'b0;
  bit tick_en = 1'b1;
  int tick_per = 1;

  // slave model
  logic [15:0] slv_data = '0;
  int          slv_bits = 8;
  int          slv_k = 0;
  logic [15:0] cap = '0;
  int          edges = 0;
  logic [31:0] rv;

  always #2 clk = ~clk;

  spi_word_master uut (
    .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(bus_addr), .bus_we_i(bus_we),
    .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata), .sclk_tick_i(tick),
    .sclk_o(sclk), .mosi_o(mosi), .miso_i(miso), .cs_n_o(cs_n), .irq_o(irq)
  );

  assign miso = (slv_k < slv_bits) ? slv_data[slv_bits-1-slv_k] : 1'b0;
  always @(posedge sclk) begin cap = {cap[14:0], mosi}; edges++; end
  always @(negedge sclk) slv_k++;

  initial begin
    int cnt = 0;
    forever begin
      @(negedge clk);
      cnt++;
      if (cnt >= tick_per) begin tick = tick_en; cnt = 0; end
      else tick = 1'b0;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic rd(logic [4:0] a);
    @(negedge clk); bus_addr = a; #1 rv = bus_rdata;
  endtask

  task automatic wait_ready(string req);
    bit got = 1'b0;
    for (int n = 0; n < 3000 && !got; n++) begin
      rd(A_CTRL);
      got = rv[1];
    end
    chk({req, " ready"}, 32'(got), 32'd1);
  endtask

  task automatic arm_slave(bit w16, logic [15:0] sw);
    slv_data = sw; slv_bits = w16 ? 16 : 8; slv_k = 0; cap = '0; edges = 0;
  endtask

  task automatic xfer(bit w16, logic [15:0] tx, logic [15:0] sw, string req);
    logic [15:0] m = w16 ? 16'hFFFF : 16'h00FF;
    arm_slave(w16, sw);
    wr(A_DOUT, {16'hDEAD, tx});
    wait_ready(req);
    chk({req, " mosi"}, 32'(cap & m), 32'(tx & m));
    chk({req, " pulses"}, 32'(edges), w16 ? 32'd16 : 32'd8);
    rd(A_DIN);
    chk({req, " din"}, rv, 32'(sw & m));
    chk({req, " sclk idle"}, 32'(sclk), 32'd0);
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 cs", 32'(cs_n), 32'hFF);
    chk("R1 sclk", 32'(sclk), 0);
    chk("R1 mosi", 32'(mosi), 0);
    chk("R1 irq", 32'(irq), 0);
    for (int a = 0; a < 6; a++) begin
      rd(5'(a * 4));
      chk("R1 reg zero", rv, 0);
    end
    // R2 R3 sweep of index and enable
    for (int i = 0; i < 8; i++) begin
      for (int e = 0; e < 2; e++) begin
        wr(A_CTRL, 32'((i << 2) | e));
        rd(A_CTRL);
        chk("R2 ctrl readback", rv, 32'((i << 2) | e));
        chk("R3 cs decode", 32'(cs_n), e ? 32'(~(8'b1 << i) & 8'hFF) : 32'hFF);
      end
    end
    wr(A_CTRL, 32'h2);
    rd(A_CTRL);
    chk("R2 ready bit read-only", rv, 0);
    wr(A_CFG, 32'hFFFF_FFFF);
    rd(A_CFG);
    chk("R2 cfg bit5", rv, 32'h20);
    wr(A_MASK, 32'hFFFF_FFFF);
    rd(A_MASK);
    chk("R2 mask bit0", rv, 1);
    wr(A_MASK, 0);
    wr(A_CFG, 0);
    wr(A_CTRL, 32'h5);  // index 1, enabled

    // R7 exact completion cycle, 8-bit, tick every cycle
    arm_slave(1'b0, 16'h0096);
    wr(A_DOUT, 32'h0000_00C3);
    repeat (15) @(negedge clk);
    bus_addr = A_CTRL; #1;
    chk("R7 ready before last edge", 32'(bus_rdata[1]), 0);
    @(negedge clk); bus_addr = A_CTRL; #1;
    chk("R7 ready at last edge", 32'(bus_rdata[1]), 1);
    chk("R7 sclk low", 32'(sclk), 0);
    bus_addr = A_DIN; #1;
    chk("R7 din", bus_rdata, 32'h96);
    chk("R4 mosi msb first", 32'(cap[7:0]), 32'hC3);

    // R5 8-bit sweep
    for (int v = 0; v < 16; v++) begin
      logic [15:0] t = 16'((v * 16'h3B1D) ^ 16'hA55A);
      logic [15:0] s = 16'((v * 16'h1F37) + 16'h0101);
      xfer(1'b0, t, s, "R5");
    end
    // R6 16-bit sweep with a slower tick
    wr(A_CFG, 32'h20);
    tick_per = 3;
    for (int v = 0; v < 8; v++) begin
      logic [15:0] t = 16'((v * 16'h9E37) ^ 16'h8001);
      logic [15:0] s = 16'((v * 16'h4A5B) ^ 16'hF00F);
      xfer(1'b1, t, s, "R6");
    end
    tick_per = 1;

    // R4 ready cleared by a new start
    arm_slave(1'b1, 16'h1234);
    wr(A_DOUT, 32'h0000_5555);
    bus_addr = A_CTRL; #1;
    chk("R4 ready cleared", 32'(bus_rdata[1]), 0);
    wait_ready("R4");

    // R8 no ticks -> no clock movement
    tick_en = 1'b0;
    arm_slave(1'b1, 16'hBEEF);
    wr(A_DOUT, 32'h0000_1357);
    repeat (6) begin
      @(negedge clk);
      chk("R8 sclk frozen", 32'(sclk), 0);
    end
    chk("R8 no pulses", 32'(edges), 0);
    tick_en = 1'b1;
    wait_ready("R8");
    chk("R8 pulses", 32'(edges), 16);
    chk("R8 mosi", 32'(cap), 32'h1357);

    // R11 size change mid-transfer
    arm_slave(1'b1, 16'hC0DE);
    wr(A_DOUT, 32'h0000_ABCD);
    wr(A_CFG, 0);
    wait_ready("R11");
    chk("R11 pulses", 32'(edges), 16);
    chk("R11 mosi", 32'(cap), 32'hABCD);
    rd(A_DIN);
    chk("R11 din", rv, 32'hC0DE);

    // R10 write while busy ignored
    arm_slave(1'b0, 16'h005A);
    wr(A_DOUT, 32'h0000_00A5);
    wr(A_DOUT, 32'h0000_003C);
    wait_ready("R10");
    chk("R10 pulses", 32'(edges), 8);
    chk("R10 mosi", 32'(cap[7:0]), 32'hA5);
    rd(A_DOUT);
    chk("R10 dout readback", rv, 32'hA5);

    // R9 cause / mask / irq
    rd(A_CAUSE);
    chk("R9 cause set", rv, 1);
    chk("R9 irq masked", 32'(irq), 0);
    wr(A_MASK, 1);
    @(negedge clk);
    chk("R9 irq on", 32'(irq), 1);
    wr(A_CAUSE, 0);
    @(negedge clk);
    chk("R9 write 0 no effect", 32'(irq), 1);
    wr(A_CAUSE, 1);
    @(negedge clk);
    chk("R9 irq cleared", 32'(irq), 0);
    rd(A_CAUSE);
    chk("R9 cause cleared", rv, 0);
    xfer(1'b0, 16'h0081, 16'h0042, "R9 refire");
    chk("R9 irq after done", 32'(irq), 1);

    // R3 cs follows enable after transfers
    wr(A_CTRL, 32'h1C);
    chk("R3 cs disabled", 32'(cs_n), 32'hFF);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule